// File: doc/BRIEF.md
# I2C Target with Word-Access Byte Files

This block is an I2C target that answers at one fixed 7-bit device address. Bytes the bus controller writes to it are packed into a 64-byte receive file. Bytes the controller reads from it come from a separate 64-byte transmit file. Both bus lines are sampled on the system clock. The block drives SDA only by pulling it low, through `sda_oe`.

A local CPU port reads and writes the two files only as whole 32-bit words, with byte offset n held in word n/4, lane n%4. The receive pointer counts received data bytes and wraps at 64. Software keeps its previous value and takes the difference modulo 64 to learn how many new bytes have arrived. The transmit pointer counts bits sent and wraps at 512. Its byte part selects the next byte to send. A sticky status bit records the end of each write transaction. An enable bit gates that status onto the interrupt output.

CPU word map:

| Word address | Content |
|---|---|
| 0–15 | receive file |
| 16–31 | transmit file |
| 32 | receive pointer, bits 5:0 |
| 33 | transmit bit pointer, bits 8:0 |
| 34 | interrupt enable, bit 0 |
| 35 | interrupt status, bit 0, cleared by writing 1 |

Top module: `i2c_word_target`

## Requirements
- R1: An address byte whose upper seven bits equal 0x50 is ACKed by pulling SDA low during the ninth clock. Any other address gets no ACK, no data is stored, and SDA stays released until the next START.
- R2: In a write transaction, every data byte is ACKed. Data byte k is stored at byte offset p = receive pointer, that is word p/4, bits 8*(p%4)+7 down to 8*(p%4).
- R3: The receive pointer (word 32) increments by one for each stored data byte and wraps from 63 to 0. The address byte does not count.
- R4: A CPU write to word 32 or word 33 loads the written value into that pointer, so writing zero restarts it.
- R5: In a read transaction (R/W bit 1), the block sends the transmit-file byte at offset transmit-pointer/8, MSB first. After each byte the controller ACKs, it continues with the following byte. Byte packing is the same as in R2.
- R6: The transmit pointer (word 33) increments once per bit sent, and so by 8 per byte. It wraps from 511 to 0.
- R7: After the controller NACKs a read byte, SDA stays released. A STOP always releases SDA and returns the block to idle.
- R8: A STOP or repeated START that ends a write transaction to the matching address sets the status bit (word 35 bit 0), even when no data bytes were sent. A read transaction does not set it. Writing 1 to bit 0 of word 35 clears the status. `irq` equals status AND enable (word 34 bit 0).
- R9: After reset both pointers are 0, the status and enable bits are 0, SDA is released, the receive file is all zeros, and every transmit word is 0xFFFFFFFF, so an early read returns 0xFF bytes.
- R10: CPU writes to words 0–15 are ignored and leave the receive file unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| cpu_sel | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU write when 1, read when 0 |
| cpu_addr | input | 6 | CPU word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data (combinational) |
| irq | output | 1 | Write-complete interrupt |

## Verification
A wrong bit count or a wrong protocol state shows up at the ports within one SCL period, as a missing or misplaced ACK or as SDA held low after a NACK or STOP. A pointer that steps wrongly, or that misses its wrap, shows on the next CPU read of words 32/33. It also shows in the stored or returned byte values of the following transaction, so the bench compares every receive word and every read byte against its own byte-array model. An interrupt status that is wrongly set or not cleared is visible on word 35 and on `irq` a few clocks after the STOP.

// File: rtl/i2c_wt_pkg.sv
package i2c_wt_pkg;
  parameter int FILE_BYTES = 64;
  parameter logic [6:0] DEV_ADDR = 7'h50;

  localparam int WORDS  = FILE_BYTES / 4;
  localparam int PTR_W  = $clog2(FILE_BYTES);
  localparam int BPTR_W = PTR_W + 3;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int CPU_AW = WIDX_W + 2;

  localparam logic [CPU_AW-1:0] A_RXPTR = CPU_AW'(2 * WORDS + 0);
  localparam logic [CPU_AW-1:0] A_TXPTR = CPU_AW'(2 * WORDS + 1);
  localparam logic [CPU_AW-1:0] A_IEN   = CPU_AW'(2 * WORDS + 2);
  localparam logic [CPU_AW-1:0] A_ISTAT = CPU_AW'(2 * WORDS + 3);

  typedef enum logic [2:0] {
    LK_IDLE, LK_ADDR, LK_ADDR_ACK, LK_RX, LK_RX_ACK, LK_TX, LK_TX_ACK
  } link_state_t;

  // word holding a byte offset
  function automatic logic [WIDX_W-1:0] word_of(input logic [PTR_W-1:0] b);
    return b[PTR_W-1:2];
  endfunction

  // byte lane inside that word
  function automatic logic [1:0] lane_of(input logic [PTR_W-1:0] b);
    return b[1:0];
  endfunction

  // bit inside a word for a transmit bit pointer, MSB of each byte first
  function automatic logic [4:0] tx_bit_pos(input logic [BPTR_W-1:0] p);
    return {p[4:3], ~p[2:0]};
  endfunction
endpackage

// File: rtl/i2c_wt_sync.sv
module i2c_wt_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int NL = 2;
  logic [NL-1:0] raw;
  logic [NL-1:0] cur;
  logic [NL-1:0] prv;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic m1, m2, m3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m1 <= 1'b1; m2 <= 1'b1; m3 <= 1'b1;
      end else begin
        m1 <= raw[g]; m2 <= m1; m3 <= m2;
      end
    end
    assign cur[g] = m2;
    assign prv[g] = m3;
  end

  assign sda_lvl   = cur[1];
  assign scl_rise  = cur[0] & ~prv[0];
  assign scl_fall  = ~cur[0] & prv[0];
  assign start_evt = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_evt  = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/i2c_wt_link.sv
module i2c_wt_link
  import i2c_wt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       sda_lvl,
  input  logic       tx_cur_bit,
  output logic       sda_oe,
  output logic       rx_wr_en,
  output logic [7:0] rx_byte,
  output logic       tx_adv,
  output logic       wr_end,
  output logic       busy
);
  link_state_t st;
  logic [2:0]  cnt;
  logic [6:0]  sh;
  logic        ack_ph, rw, wr_act;
  logic [7:0]  nxt;
  logic        quiet;

  assign nxt     = {sh, sda_lvl};
  assign quiet   = ~start_evt & ~stop_evt;
  assign rx_byte = nxt;
  assign rx_wr_en = quiet & (st == LK_RX) & scl_rise & (cnt == 3'd7);
  assign tx_adv   = quiet & (st == LK_TX) & scl_rise;
  assign wr_end   = wr_act & (start_evt | stop_evt);
  assign busy     = (st != LK_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= LK_IDLE; cnt <= '0; sh <= '0; ack_ph <= 1'b0;
      rw <= 1'b0; wr_act <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st <= LK_IDLE; sda_oe <= 1'b0; wr_act <= 1'b0;
    end else if (start_evt) begin
      st <= LK_ADDR; cnt <= '0; sda_oe <= 1'b0; wr_act <= 1'b0;
    end else begin
      unique case (st)
        LK_ADDR: if (scl_rise) begin
          sh  <= nxt[6:0];
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (nxt[7:1] == DEV_ADDR) begin
              st <= LK_ADDR_ACK; ack_ph <= 1'b0;
              rw <= nxt[0]; wr_act <= ~nxt[0];
            end else begin
              st <= LK_IDLE;
            end
          end
        end
        LK_ADDR_ACK, LK_RX_ACK: if (scl_fall) begin
          if (!ack_ph) begin
            sda_oe <= 1'b1; ack_ph <= 1'b1;
          end else begin
            ack_ph <= 1'b0; cnt <= '0;
            if (st == LK_ADDR_ACK && rw) begin
              st <= LK_TX; sda_oe <= ~tx_cur_bit;
            end else begin
              st <= LK_RX; sda_oe <= 1'b0;
            end
          end
        end
        LK_RX: if (scl_rise) begin
          sh  <= nxt[6:0];
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            st <= LK_RX_ACK; ack_ph <= 1'b0;
          end
        end
        LK_TX: begin
          if (scl_fall) sda_oe <= ~tx_cur_bit;
          if (scl_rise) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) st <= LK_TX_ACK;
          end
        end
        LK_TX_ACK: begin
          if (scl_fall) sda_oe <= 1'b0;
          if (scl_rise) begin
            cnt <= '0;
            st  <= sda_lvl ? LK_IDLE : LK_TX;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_wt_regs.sv
module i2c_wt_regs
  import i2c_wt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  input  logic              rx_wr_en,
  input  logic [7:0]        rx_byte,
  input  logic              tx_adv,
  input  logic              wr_end,
  output logic              tx_cur_bit,
  output logic              irq,
  output logic [PTR_W-1:0]  rx_ptr,
  output logic [BPTR_W-1:0] tx_ptr,
  output logic              irq_stat
);
  logic [31:0] rx_mem [WORDS];
  logic [31:0] tx_mem [WORDS];
  logic        irq_en;
  logic        cpu_wr;
  logic        is_reg;
  logic [WIDX_W-1:0] idx;

  assign cpu_wr = cpu_sel & cpu_we;
  assign is_reg = cpu_addr[CPU_AW-1];
  assign idx    = cpu_addr[WIDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        rx_mem[i] <= '0;
        tx_mem[i] <= '1;
      end
    end else begin
      if (rx_wr_en)
        rx_mem[word_of(rx_ptr)][8*lane_of(rx_ptr) +: 8] <= rx_byte;
      if (cpu_wr && !is_reg && cpu_addr[CPU_AW-2])
        tx_mem[idx] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ptr <= '0; tx_ptr <= '0; irq_en <= 1'b0; irq_stat <= 1'b0;
    end else begin
      if (cpu_wr && cpu_addr == A_RXPTR) rx_ptr <= cpu_wdata[PTR_W-1:0];
      else if (rx_wr_en)                 rx_ptr <= rx_ptr + 1'b1;
      if (cpu_wr && cpu_addr == A_TXPTR) tx_ptr <= cpu_wdata[BPTR_W-1:0];
      else if (tx_adv)                   tx_ptr <= tx_ptr + 1'b1;
      if (cpu_wr && cpu_addr == A_IEN) irq_en <= cpu_wdata[0];
      if (wr_end) irq_stat <= 1'b1;
      else if (cpu_wr && cpu_addr == A_ISTAT && cpu_wdata[0]) irq_stat <= 1'b0;
    end
  end

  assign tx_cur_bit = tx_mem[tx_ptr[BPTR_W-1 -: WIDX_W]][tx_bit_pos(tx_ptr)];
  assign irq        = irq_stat & irq_en;

  always_comb begin
    cpu_rdata = '0;
    if (!is_reg) begin
      cpu_rdata = cpu_addr[CPU_AW-2] ? tx_mem[idx] : rx_mem[idx];
    end else begin
      unique case (cpu_addr[1:0])
        2'd0: cpu_rdata = 32'(rx_ptr);
        2'd1: cpu_rdata = 32'(tx_ptr);
        2'd2: cpu_rdata = {31'b0, irq_en};
        default: cpu_rdata = {31'b0, irq_stat};
      endcase
    end
  end
endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target
  import i2c_wt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              irq
);
  logic sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic tx_cur_bit, rx_wr_en, tx_adv, wr_end, busy, irq_stat;
  logic [7:0]        rx_byte;
  logic [PTR_W-1:0]  rx_ptr;
  logic [BPTR_W-1:0] tx_ptr;

  i2c_wt_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_wt_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_lvl(sda_lvl),
    .tx_cur_bit(tx_cur_bit), .sda_oe(sda_oe), .rx_wr_en(rx_wr_en),
    .rx_byte(rx_byte), .tx_adv(tx_adv), .wr_end(wr_end), .busy(busy)
  );

  i2c_wt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rx_wr_en(rx_wr_en), .rx_byte(rx_byte), .tx_adv(tx_adv),
    .wr_end(wr_end), .tx_cur_bit(tx_cur_bit), .irq(irq),
    .rx_ptr(rx_ptr), .tx_ptr(tx_ptr), .irq_stat(irq_stat)
  );
endmodule

// File: rtl/i2c_wt_check.sv
module i2c_wt_check
  import i2c_wt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              stop_evt,
  input logic              busy,
  input logic              scl_rise,
  input logic              rx_wr_en,
  input logic [PTR_W-1:0]  rx_ptr,
  input logic              tx_adv,
  input logic [BPTR_W-1:0] tx_ptr,
  input logic              irq_stat,
  input logic              wr_end,
  input logic              cpu_sel,
  input logic              cpu_we,
  input logic [CPU_AW-1:0] cpu_addr
);
  logic rx_load, tx_load;
  assign rx_load = cpu_sel & cpu_we & (cpu_addr == A_RXPTR);
  assign tx_load = cpu_sel & cpu_we & (cpu_addr == A_TXPTR);

  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe && !busy));

  p_no_drive_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe);

  p_store_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_en |-> scl_rise);

  p_rx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr_en && !rx_load) |=> rx_ptr == PTR_W'($past(rx_ptr) + 1'b1));

  p_tx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_adv && !tx_load) |=> tx_ptr == BPTR_W'($past(tx_ptr) + 1'b1));

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat) |-> $past(wr_end));
endmodule

bind i2c_word_target i2c_wt_check u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .stop_evt(stop_evt),
  .busy(busy), .scl_rise(scl_rise), .rx_wr_en(rx_wr_en), .rx_ptr(rx_ptr),
  .tx_adv(tx_adv), .tx_ptr(tx_ptr), .irq_stat(irq_stat), .wr_end(wr_end),
  .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr)
);

// File: tb/i2c_word_target_test.sv
`timescale 1ns/1ps
module i2c_word_target_test;
  localparam int Q = 10;
  localparam int NV = 6;
  // {dev7, d0, d1, expected address ACK}
  localparam logic [23:0] VEC [NV] = '{
    {7'h50, 8'h11, 8'h22, 1'b1},
    {7'h51, 8'h33, 8'h44, 1'b0},
    {7'h50, 8'hA5, 8'h5A, 1'b1},
    {7'h28, 8'h99, 8'h88, 1'b0},
    {7'h50, 8'h00, 8'hFF, 1'b1},
    {7'h10, 8'h01, 8'h02, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1;
  logic sda_oe, irq, sda_line;
  logic cpu_sel = 1'b0, cpu_we = 1'b0;
  logic [5:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] mrx [64];
  logic [5:0] mptr = '0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  i2c_word_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic cpu_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_sel = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk); cpu_sel = 1'b0;
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(); scl = 1'b1; wq(); sda_drv = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(); scl = 1'b1; wq(); sda_drv = 1'b1; wq(); wq();
  endtask

  task automatic put_bit(input logic b);
    sda_drv = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_drv = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic last);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(last);
  endtask

  task automatic chk_rx_file(input string req);
    logic [31:0] d;
    for (int w = 0; w < 16; w++) begin
      cpu_rd(6'(w), d);
      chk(req, d, {mrx[4*w+3], mrx[4*w+2], mrx[4*w+1], mrx[4*w]});
    end
  endtask

  task automatic model_put(input logic [7:0] v);
    mrx[mptr] = v; mptr = mptr + 6'd1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic a, a1, a2;
    logic [7:0] rb;
    for (int i = 0; i < 64; i++) mrx[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 reset state
    chk("R9 sda released", 32'(sda_oe), 0);
    chk("R9 irq low", 32'(irq), 0);
    cpu_rd(6'd32, d); chk("R9 rx ptr", d, 0);
    cpu_rd(6'd33, d); chk("R9 tx ptr", d, 0);
    cpu_rd(6'd35, d); chk("R9 status", d, 0);
    cpu_rd(6'd16, d); chk("R9 tx word0 ones", d, 32'hFFFFFFFF);
    cpu_rd(6'd3,  d); chk("R9 rx word zero", d, 0);

    // table of write transactions: R1 R2 R3 R8
    for (int v = 0; v < NV; v++) begin
      bus_start();
      put_byte({VEC[v][23:17], 1'b0}, a);
      chk("R1 address ack", 32'(a), 32'(VEC[v][0]));
      if (a) begin
        put_byte(VEC[v][16:9], a1);
        put_byte(VEC[v][8:1], a2);
        chk("R2 data acks", {30'b0, a1, a2}, 32'd3);
        model_put(VEC[v][16:9]);
        model_put(VEC[v][8:1]);
      end
      bus_stop();
      cpu_rd(6'd32, d); chk("R3 rx ptr count", d, 32'(mptr));
      cpu_rd(6'd35, d); chk("R8 status after write", d, 32'(VEC[v][0]));
      cpu_wr(6'd35, 32'h1);
      cpu_rd(6'd35, d); chk("R8 status w1c", d, 0);
    end
    chk_rx_file("R2 rx packing");

    // R4 R3 wrap of receive pointer
    cpu_wr(6'd32, 32'd62); mptr = 6'd62;
    cpu_rd(6'd32, d); chk("R4 rx ptr load", d, 62);
    bus_start();
    put_byte({7'h50, 1'b0}, a);
    for (int k = 0; k < 4; k++) begin
      put_byte(8'hC1 + 8'(k), a1);
      model_put(8'hC1 + 8'(k));
    end
    bus_stop();
    cpu_rd(6'd32, d); chk("R3 rx ptr wrap", d, 2);
    chk_rx_file("R2 R3 wrap packing");
    cpu_wr(6'd35, 32'h1);

    // R10 receive file is not CPU-writable
    cpu_wr(6'd0, 32'hDEADBEEF);
    chk_rx_file("R10 rx write ignored");

    // R9 R5 read before data prepared
    bus_start();
    put_byte({7'h50, 1'b1}, a);
    chk("R1 read address ack", 32'(a), 1);
    get_byte(rb, 1'b1);
    bus_stop();
    chk("R9 early read 0xFF", 32'(rb), 32'hFF);
    cpu_rd(6'd33, d); chk("R6 tx ptr one byte", d, 8);

    // R5 R6 R7 multi-byte read
    cpu_wr(6'd16, 32'h44332211);
    cpu_wr(6'd17, 32'h88776655);
    cpu_wr(6'd33, 32'd0);
    cpu_rd(6'd33, d); chk("R4 tx ptr zero", d, 0);
    bus_start();
    put_byte({7'h50, 1'b1}, a);
    for (int k = 0; k < 5; k++) begin
      get_byte(rb, (k == 4));
      chk("R5 read byte", 32'(rb), 32'(8'h11 * (k + 1)));
    end
    wq();
    chk("R7 released after nack", 32'(sda_oe), 0);
    get_bit(a1);
    chk("R7 no drive after nack", 32'(a1), 1);
    bus_stop();
    chk("R7 released after stop", 32'(sda_oe), 0);
    cpu_rd(6'd33, d); chk("R6 tx ptr bits", d, 40);
    cpu_rd(6'd35, d); chk("R8 read sets no status", d, 0);

    // R5 start mid-file
    cpu_wr(6'd33, 32'd48);
    bus_start();
    put_byte({7'h50, 1'b1}, a);
    get_byte(rb, 1'b1);
    bus_stop();
    chk("R5 offset 6 byte", 32'(rb), 32'h77);

    // R6 wrap of transmit pointer
    cpu_wr(6'd31, 32'hC3000000);
    cpu_wr(6'd33, 32'd504);
    bus_start();
    put_byte({7'h50, 1'b1}, a);
    get_byte(rb, 1'b1);
    bus_stop();
    chk("R5 last byte", 32'(rb), 32'hC3);
    cpu_rd(6'd33, d); chk("R6 tx ptr wrap", d, 0);

    // R8 interrupt enable and address-only write
    cpu_wr(6'd34, 32'h1);
    chk("R8 irq idle", 32'(irq), 0);
    bus_start();
    put_byte({7'h50, 1'b0}, a);
    bus_stop();
    chk("R8 irq raised", 32'(irq), 1);
    cpu_wr(6'd35, 32'h1);
    chk("R8 irq cleared", 32'(irq), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule